// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block generates the logic-level timing for a full-frame CCD: two vertical transfer phases, two horizontal shift phases, the reset-gate clock for the output sense node, and a one-cycle strobe for an external ADC. A frame begins when software raises a start request. The sequencer then integrates with the vertical phases parked low. After that it reads out a programmed number of lines. Each line is a vertical transfer, a setup gap, and a run of horizontal pixel periods. Frame and line markers tell downstream capture logic where the data begins. All timing values are parameters expressed in system-clock ticks.

A free-running pixel-phase counter sets the pace of the whole sequencer. The reset gate runs from this counter without pause, including while the sequencer is idle. Integration, transfer and shifting all begin on a pixel boundary. For that to hold, the parameters must satisfy one rule: `3*T_VPULSE + T_SETUP` must be a multiple of `T_PIX`. With the defaults (40 MHz system clock) the pixel rate is 4 MHz, each vertical pulse lasts 20 µs, and the setup gap is 1 µs. There is no data path through the block, so every pin is a plain control or status signal.

Top module: `ccd_seq_top`

## Requirements
- R1: A synchronous reset leaves the block idle. In that state `vclk1`=`vclk2`=0, `hclk1`=1, `hclk2`=0, and `frame_mark`, `line_mark` and `adc_strobe` are all 0.
- R2: A `start_req` pulse seen while idle starts integration at the next pixel boundary. Integration lasts max(`integ_len`,1) pixel periods. Throughout integration `vclk1` and `vclk2` stay low.
- R3: Each line opens with a vertical transfer made of three equal slots of `T_VPULSE` ticks. `vclk1` is high in the first slot and `vclk2` is high in the second; the two are never high together. `hclk1`=1 and `hclk2`=0 for the whole transfer, so `vclk2` falls while `hclk1` is high.
- R4: A gap of `T_SETUP` ticks follows the transfer. During the gap `hclk1` stays 1 and `hclk2` stays 0.
- R5: Each line then shifts `N_PIX` pixel periods. In the first half of each period `hclk1`=0 and `hclk2`=1; in the second half `hclk1`=1 and `hclk2`=0. `hclk2` therefore falls once per period, at its midpoint.
- R6: A line lasts `3*T_VPULSE + T_SETUP + N_PIX*T_PIX` ticks. A frame holds `N_LINE` lines. With no request pending, the block returns to idle afterwards.
- R7: `rgate` is high for the first `RG_W` ticks of every pixel period. It rises exactly once every `T_PIX` ticks in every state.
- R8: `adc_strobe` is high for one tick per shifted pixel, at pixel phase `sample_phase` (valid range `RG_W`..`T_PIX-1`). It never coincides with `rgate` and never fires outside shifting.
- R9: `frame_mark` is high for one tick, on the first tick of line 1's vertical transfer. `line_mark` is high for one tick, on the first tick of each line's first pixel period.
- R10: A `start_req` during integration or readout is remembered. Integration for the next frame then begins on the tick after the current frame ends. Several such requests produce only one extra frame.
- R11: A synchronous reset mid-frame abandons the frame and discards any remembered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request one frame (integration then readout) |
| integ_len | input | INT_W | Integration length in pixel periods |
| sample_phase | input | PH_W | Pixel phase of the ADC strobe |
| vclk1 | output | 1 | Vertical transfer phase 1 |
| vclk2 | output | 1 | Vertical transfer phase 2 |
| hclk1 | output | 1 | Horizontal shift phase 1 |
| hclk2 | output | 1 | Horizontal shift phase 2 |
| rgate | output | 1 | Sense-node reset clock |
| adc_strobe | output | 1 | One-tick ADC sample strobe |
| frame_mark | output | 1 | First tick of readout line 1 |
| line_mark | output | 1 | First tick of each line's first pixel |

## Verification
The bench compares every readout tick of whole frames against a waveform model computed from the requirements. A slot that is one tick off, or a wrong `hclk` polarity during the setup gap, fails the R3/R4 group. A design that aligned shifting to something other than the pixel boundary would move `hclk2` edges against `rgate` and fail R5/R7. Integration length zero must behave like one period, and an off-by-one integration counter shows up as a `frame_mark` arriving four ticks early or late. A start request that is forgotten, duplicated, or allowed to survive a mid-frame reset shows up as a missing, extra or early second frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_INTEG = 2'd1,
    SEQ_XFER  = 2'd2,
    SEQ_SHIFT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
  parameter int T_PIX = 10,
  parameter int RG_W  = 2,
  localparam int PH_W = $clog2(T_PIX)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            pix_end,
  output logic            rgate
);
  logic [PH_W-1:0] ph_q;

  assign pix_end = (ph_q == PH_W'(T_PIX - 1));
  assign phase   = ph_q;
  assign rgate   = (ph_q < PH_W'(RG_W));

  always_ff @(posedge clk) begin
    if (rst)          ph_q <= '0;
    else if (pix_end) ph_q <= '0;
    else              ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/ccd_line_fsm.sv
module ccd_line_fsm
  import ccd_seq_pkg::*;
#(
  parameter int T_VPULSE = 800,
  parameter int T_SETUP  = 40,
  parameter int N_PIX    = 3100,
  parameter int N_LINE   = 2056,
  parameter int INT_W    = 24,
  localparam int XFER_T  = 3 * T_VPULSE + T_SETUP,
  localparam int TW      = $clog2(XFER_T),
  localparam int PW      = $clog2(N_PIX),
  localparam int LW      = $clog2(N_LINE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [INT_W-1:0] integ_len,
  input  logic             pix_end,
  output seq_state_t       state,
  output logic [TW-1:0]    tcnt,
  output logic [PW-1:0]    pcnt,
  output logic [LW-1:0]    line,
  output logic             pend
);
  logic [INT_W-1:0] icnt;
  logic             req;

  assign req = start_req | pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      pend  <= 1'b0;
      icnt  <= '0;
      tcnt  <= '0;
      pcnt  <= '0;
      line  <= '0;
    end else begin
      pend <= pend | start_req;
      unique case (state)
        SEQ_IDLE: begin
          if (pix_end && req) begin
            state <= SEQ_INTEG;
            icnt  <= '0;
            pend  <= 1'b0;
          end
        end
        SEQ_INTEG: begin
          if (pix_end) begin
            if ((INT_W+1)'(icnt) + 1'b1 >= (INT_W+1)'(integ_len)) begin
              state <= SEQ_XFER;
              tcnt  <= '0;
              line  <= '0;
            end else begin
              icnt <= icnt + 1'b1;
            end
          end
        end
        SEQ_XFER: begin
          if (tcnt == TW'(XFER_T - 1)) begin
            state <= SEQ_SHIFT;
            pcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SEQ_SHIFT: begin
          if (pix_end) begin
            if (pcnt == PW'(N_PIX - 1)) begin
              if (line == LW'(N_LINE - 1)) begin
                if (req) begin
                  state <= SEQ_INTEG;
                  icnt  <= '0;
                  pend  <= 1'b0;
                end else begin
                  state <= SEQ_IDLE;
                end
              end else begin
                line  <= line + 1'b1;
                tcnt  <= '0;
                state <= SEQ_XFER;
              end
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_phase_decode.sv
module ccd_phase_decode
  import ccd_seq_pkg::*;
#(
  parameter int T_PIX    = 10,
  parameter int T_VPULSE = 800,
  parameter int T_SETUP  = 40,
  parameter int N_PIX    = 3100,
  parameter int N_LINE   = 2056,
  localparam int PH_W    = $clog2(T_PIX),
  localparam int XFER_T  = 3 * T_VPULSE + T_SETUP,
  localparam int TW      = $clog2(XFER_T),
  localparam int PW      = $clog2(N_PIX),
  localparam int LW      = $clog2(N_LINE)
) (
  input  seq_state_t      state,
  input  logic [TW-1:0]   tcnt,
  input  logic [PW-1:0]   pcnt,
  input  logic [LW-1:0]   line,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] sample_phase,
  output logic            vclk1,
  output logic            vclk2,
  output logic            hclk1,
  output logic            hclk2,
  output logic            adc_strobe,
  output logic            frame_mark,
  output logic            line_mark
);
  logic in_xfer, in_shift, first_half;

  always_comb begin
    in_xfer    = (state == SEQ_XFER);
    in_shift   = (state == SEQ_SHIFT);
    first_half = (phase < PH_W'(T_PIX / 2));
    vclk1      = in_xfer && (tcnt < TW'(T_VPULSE));
    vclk2      = in_xfer && (tcnt >= TW'(T_VPULSE)) && (tcnt < TW'(2 * T_VPULSE));
    hclk2      = in_shift && first_half;
    hclk1      = !(in_shift && first_half);
    adc_strobe = in_shift && (phase == sample_phase);
    frame_mark = in_xfer && (line == '0) && (tcnt == '0);
    line_mark  = in_shift && (pcnt == '0) && (phase == '0);
  end
endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int T_PIX    = 10,
  parameter int T_VPULSE = 800,
  parameter int T_SETUP  = 40,
  parameter int N_PIX    = 3100,
  parameter int N_LINE   = 2056,
  parameter int RG_W     = 2,
  parameter int INT_W    = 24,
  localparam int PH_W    = $clog2(T_PIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [INT_W-1:0] integ_len,
  input  logic [PH_W-1:0]  sample_phase,
  output logic             vclk1,
  output logic             vclk2,
  output logic             hclk1,
  output logic             hclk2,
  output logic             rgate,
  output logic             adc_strobe,
  output logic             frame_mark,
  output logic             line_mark
);
  localparam int XFER_T = 3 * T_VPULSE + T_SETUP;
  localparam int TW     = $clog2(XFER_T);
  localparam int PW     = $clog2(N_PIX);
  localparam int LW     = $clog2(N_LINE);

  seq_state_t      state;
  logic [TW-1:0]   tcnt;
  logic [PW-1:0]   pcnt;
  logic [LW-1:0]   line;
  logic [PH_W-1:0] phase;
  logic            pix_end;
  logic            pend;

  ccd_pix_timer #(.T_PIX(T_PIX), .RG_W(RG_W)) timer_i (
    .clk(clk), .rst(rst), .phase(phase), .pix_end(pix_end), .rgate(rgate)
  );

  ccd_line_fsm #(
    .T_VPULSE(T_VPULSE), .T_SETUP(T_SETUP), .N_PIX(N_PIX),
    .N_LINE(N_LINE), .INT_W(INT_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .start_req(start_req), .integ_len(integ_len),
    .pix_end(pix_end), .state(state), .tcnt(tcnt), .pcnt(pcnt),
    .line(line), .pend(pend)
  );

  ccd_phase_decode #(
    .T_PIX(T_PIX), .T_VPULSE(T_VPULSE), .T_SETUP(T_SETUP),
    .N_PIX(N_PIX), .N_LINE(N_LINE)
  ) dec_i (
    .state(state), .tcnt(tcnt), .pcnt(pcnt), .line(line), .phase(phase),
    .sample_phase(sample_phase), .vclk1(vclk1), .vclk2(vclk2),
    .hclk1(hclk1), .hclk2(hclk2), .adc_strobe(adc_strobe),
    .frame_mark(frame_mark), .line_mark(line_mark)
  );
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk
  import ccd_seq_pkg::*;
#(
  parameter int T_PIX = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       start_req,
  input seq_state_t state,
  input logic       pend,
  input logic       vclk1,
  input logic       vclk2,
  input logic       hclk1,
  input logic       hclk2,
  input logic       rgate,
  input logic       adc_strobe,
  input logic       frame_mark,
  input logic       line_mark
);
  logic        rg_q, seen;
  logic [31:0] gap;
  logic        rg_rise;

  assign rg_rise = rgate && !rg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rg_q <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else begin
      rg_q <= rgate;
      if (rg_rise) begin
        seen <= 1'b1;
        gap  <= 32'd1;
      end else begin
        gap <= gap + 32'd1;
      end
    end
  end

  p_integ_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_INTEG) |-> (!vclk1 && !vclk2 && !adc_strobe));

  p_v2fall_h1_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(vclk2) |-> (hclk1 && !hclk2));

  p_ls_after_gap_r4: assert property (@(posedge clk) disable iff (rst)
    line_mark |-> ($past(hclk1) && !hclk1));

  p_rg_period_r7: assert property (@(posedge clk) disable iff (rst)
    (rg_rise && seen) |-> (gap == 32'(T_PIX)));

  p_adc_clear_r8: assert property (@(posedge clk) disable iff (rst)
    adc_strobe |-> !rgate);

  p_fm_xfer_r9: assert property (@(posedge clk) disable iff (rst)
    frame_mark |-> (vclk1 && !vclk2 && hclk1));

  p_fm_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_mark |=> !frame_mark);

  p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (start_req && state != SEQ_IDLE && state != SEQ_SHIFT) |=> pend);
endmodule

bind ccd_seq_top ccd_seq_chk #(.T_PIX(T_PIX)) chk_i (
  .clk(clk), .rst(rst), .start_req(start_req), .state(state), .pend(pend),
  .vclk1(vclk1), .vclk2(vclk2), .hclk1(hclk1), .hclk2(hclk2),
  .rgate(rgate), .adc_strobe(adc_strobe), .frame_mark(frame_mark),
  .line_mark(line_mark)
);

// File: tb/ccd_seq_top_tb_top.sv
module ccd_seq_top_tb_top;
  localparam int CLK_P  = 10;
  localparam int TP     = 4;
  localparam int TV     = 6;
  localparam int TS     = 2;
  localparam int NPIX   = 5;
  localparam int NLINE  = 3;
  localparam int RGW    = 1;
  localparam int INTW   = 8;
  localparam int XT     = 3 * TV + TS;
  localparam int LINE_T = XT + NPIX * TP;
  localparam int FRAME_T = NLINE * LINE_T;

  logic clk = 1'b0, rst = 1'b1, start_req = 1'b0;
  logic [INTW-1:0] integ_len = '0;
  logic [1:0] sample_phase = 2'd1;
  logic vclk1, vclk2, hclk1, hclk2, rgate, adc_strobe, frame_mark, line_mark;
  int nchk = 0, nfail = 0;

  ccd_seq_top #(.T_PIX(TP), .T_VPULSE(TV), .T_SETUP(TS), .N_PIX(NPIX),
    .N_LINE(NLINE), .RG_W(RGW), .INT_W(INTW)) dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .integ_len(integ_len),
    .sample_phase(sample_phase), .vclk1(vclk1), .vclk2(vclk2),
    .hclk1(hclk1), .hclk2(hclk2), .rgate(rgate), .adc_strobe(adc_strobe),
    .frame_mark(frame_mark), .line_mark(line_mark));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  function automatic logic [7:0] exp_vec(input int l, input int o, input int ofs);
    logic v1e, v2e, h1e, rge, adce, fme, lme;
    int p;
    v1e = (o < TV);
    v2e = (o >= TV) && (o < 2 * TV);
    if (o < XT) begin
      h1e = 1'b1; adce = 1'b0; lme = 1'b0;
    end else begin
      p = (o - XT) % TP;
      h1e = (p >= TP / 2);
      adce = (p == ofs);
      lme = (o == XT);
    end
    rge = ((o % TP) < RGW);
    fme = (l == 0) && (o == 0);
    return {v1e, v2e, h1e, !h1e, rge, adce, fme, lme};
  endfunction

  function automatic logic [7:0] act_vec();
    return {vclk1, vclk2, hclk1, hclk2, rgate, adc_strobe, frame_mark, line_mark};
  endfunction

  // Called at the negedge where frame_mark is seen; returns at offset FRAME_T.
  task automatic scan_frame(input int ofs);
    int errs[6], fa[6], fe[6], nls;
    string names[6];
    names = '{"R3 transfer", "R4 setup gap", "R5 shifting", "R7 reset gate",
              "R8 adc strobe", "R9 markers"};
    nls = 0;
    for (int g = 0; g < 6; g++) begin errs[g] = 0; fa[g] = 0; fe[g] = 0; end
    for (int l = 0; l < NLINE; l++) begin
      for (int o = 0; o < LINE_T; o++) begin
        logic [7:0] ev, av, m[6];
        ev = exp_vec(l, o, ofs);
        av = act_vec();
        if (line_mark) nls++;
        m[0] = (o < 3 * TV) ? 8'hF0 : 8'hC0;
        m[1] = (o >= 3 * TV && o < XT) ? 8'h30 : 8'h00;
        m[2] = (o >= XT) ? 8'h30 : 8'h00;
        m[3] = 8'h08;
        m[4] = 8'h04;
        m[5] = 8'h03;
        for (int g = 0; g < 6; g++) begin
          if (((ev ^ av) & m[g]) != 8'h00) begin
            if (errs[g] == 0) begin fa[g] = int'(av & m[g]); fe[g] = int'(ev & m[g]); end
            errs[g]++;
          end
        end
        @(negedge clk);
      end
    end
    for (int g = 0; g < 6; g++)
      chk(errs[g] == 0, names[g], "first mismatching bits", fa[g], fe[g]);
    chk(nls == NLINE, "R6", "line_mark count per frame", nls, NLINE);
  endtask

  task automatic check_idle(input int cycles, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      if (vclk1 || vclk2 || !hclk1 || hclk2 || frame_mark || line_mark || adc_strobe) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, "ticks with activity while idle", bad, 0);
  endtask

  // Pulse start at pixel phase 0; leaves bench at the frame_mark negedge.
  task automatic kick_and_wait(input int it, output int c, output int vbad);
    integ_len = INTW'(it);
    while (!rgate) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    c = 1; vbad = 0;
    while (!frame_mark && c < 2000) begin
      if (vclk1 || vclk2) vbad++;
      @(negedge clk);
      c++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!vclk1 && !vclk2, "R1", "vertical phases after reset", {vclk1, vclk2}, 0);
    chk(hclk1 && !hclk2, "R1", "horizontal phases after reset", {hclk1, hclk2}, 2);
    chk(!frame_mark && !line_mark && !adc_strobe, "R1", "markers after reset",
        {frame_mark, line_mark, adc_strobe}, 0);
  endtask

  task automatic t_idle_rgate();
    int hi;
    hi = 0;
    for (int i = 0; i < 4 * TP; i++) begin
      if (rgate) hi++;
      @(negedge clk);
    end
    chk(hi == 4 * RGW, "R7", "reset-gate high ticks over 4 idle periods", hi, 4 * RGW);
    check_idle(2 * TP, "R8");
  endtask

  task automatic t_frame(input int it, input int ofs);
    int c, vbad, m;
    m = (it < 1) ? 1 : it;
    sample_phase = 2'(ofs);
    kick_and_wait(it, c, vbad);
    chk(c == (m + 1) * TP, "R2", "ticks from start to frame_mark", c, (m + 1) * TP);
    chk(vbad == 0, "R2", "vertical activity during integration", vbad, 0);
    scan_frame(ofs);
    check_idle(3 * TP, "R6");
  endtask

  task automatic t_pending();
    int c, vbad, k;
    sample_phase = 2'd2;
    kick_and_wait(1, c, vbad);
    repeat (50) @(negedge clk);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    repeat (10) @(negedge clk);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    k = 62;
    while (!frame_mark && k < 1000) begin @(negedge clk); k++; end
    chk(k == FRAME_T + TP, "R10", "ticks between queued frames", k, FRAME_T + TP);
    scan_frame(2);
    check_idle(FRAME_T, "R10");
  endtask

  task automatic t_mid_reset();
    int c, vbad;
    sample_phase = 2'd1;
    kick_and_wait(2, c, vbad);
    repeat (5) @(negedge clk);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    repeat (25) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!vclk1 && !vclk2 && hclk1 && !hclk2, "R11", "phases after mid-frame reset",
        {vclk1, vclk2, hclk1, hclk2}, 2);
    check_idle(2 * FRAME_T, "R11");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_rgate();
    t_frame(2, 1);
    t_frame(0, 3);
    t_frame(1, 2);
    t_pending();
    t_mid_reset();
    finish_run();
  end
endmodule